// File: doc/BRIEF.md
# Programmable Static Memory Read Cycle Generator

This block runs read cycles on one ROM or SRAM chip select. A host presents an address with a request. The block then drives the address, an active-low chip select and an active-low output enable in a fixed order. It samples the read data at the end of each access, hands every beat back with a one-cycle valid strobe, and marks the end of the whole cycle with a done pulse.

Each phase of the cycle takes its length from a 2- or 3-bit code in a 17-bit timing word that the host can write and read back. The codes map to clock counts that do not rise in a straight line. A page-mode burst keeps both strobes low and steps the address once per beat. After the first beat, each further beat uses a shorter page access time. A timing word is sampled only when a request is accepted, so a cycle already in progress keeps its timing. If the word names a memory type other than ROM/SRAM, requests are turned away with an error and the strobes do not move.

Top module: `smem_rd_seq`

## Requirements
- R1: After reset, mem_cs_n and mem_oe_n are 1, mem_adv is 0, req_ready is 1, rsp_valid, rsp_done and rsp_err are 0, and cfg_rdata reads 0x0700.
- R2: A write on cfg_we shows all 17 bits of cfg_wdata on cfg_rdata from the next cycle on, whether or not a cycle is running.
- R3: Timing word fields (bit positions): [14:13] address setup, [12:11] chip-select setup, [10:8] access, [7:6] chip-select hold, [5:4] address hold, [3:2] page access, [1:0] page mode, [16:15] memory type. In the first cycle after acceptance mem_adv rises. mem_cs_n falls after the address-setup count, and mem_oe_n falls after a further chip-select-setup count. Setup codes 0,1,2,3 give 0,1,2,4 clocks, and a zero count merges the phases.
- R4: mem_oe_n stays low for the access count of the first beat. Access codes 0..7 give 1,2,3,4,6,8,10,14 clocks.
- R5: After the last beat, mem_oe_n rises first. mem_cs_n rises after the chip-select-hold count and mem_adv falls after a further address-hold count. Both holds map codes 0,1,2,3 to 0,1,2,4 clocks.
- R6: Page-mode codes 0,1,2,3 give 1,4,8,16 beats. Each beat after the first lasts the page access count (codes 0..3 give 2,3,4,6 clocks), and both strobes stay low across the burst.
- R7: rsp_data holds mem_rdata as sampled on the last clock of each beat's access, with rsp_valid high for exactly the following cycle. mem_addr starts at req_addr and rises by one at each beat boundary.
- R8: req_ready is low from the cycle after acceptance until the cycle after mem_adv falls. In that cycle rsp_done is high for one cycle.
- R9: If the memory type field is not 00 when a request arrives, the next cycle shows rsp_done and rsp_err together, and mem_cs_n, mem_oe_n and mem_adv stay inactive.
- R10: A timing-word write made during a cycle does not change that cycle's timing and applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 17 | Timing word write value |
| cfg_rdata | output | 17 | Timing word readback |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Start address of the request |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| rsp_valid | output | 1 | One beat of read data is valid |
| rsp_data | output | DATA_W | Captured read data |
| rsp_done | output | 1 | Cycle finished (one-cycle pulse) |
| rsp_err | output | 1 | Request refused for a bad memory type |
| mem_addr | output | ADDR_W | Memory address |
| mem_adv | output | 1 | Address valid (drive enable) |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
A wrong phase counter or a wrong code mapping moves a strobe edge by whole clocks. The bench compares every strobe and the idle flag on every cycle of every request against a timeline it builds itself, so an error like that is reported on the first cycle it appears. A capture made one clock early or late, or an address that skips a step, shows as wrong data on the valid beat because the model memory returns a value derived from the address. A timing word that leaks into the running cycle stretches or shortens that cycle, and the mid-cycle write test catches this before the cycle's done pulse.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int CFG_W = 17;
  localparam int CNT_W = 5;

  typedef struct packed {
    logic [CNT_W-1:0] asu;
    logic [CNT_W-1:0] csu;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] pga;
    logic [CNT_W-1:0] chd;
    logic [CNT_W-1:0] ahd;
    logic [CNT_W-1:0] beats;
    logic             ok;
  } smem_tm_t;

  // 0,1,2,3 -> 0,1,2,4 clocks
  function automatic logic [CNT_W-1:0] short_clks(input logic [1:0] c);
    return (c == 2'd3) ? CNT_W'(4) : CNT_W'(c);
  endfunction

  // 0..7 -> 1,2,3,4,6,8,10,14 clocks
  function automatic logic [CNT_W-1:0] acc_clks(input logic [2:0] c);
    case (c)
      3'd4:    return CNT_W'(6);
      3'd5:    return CNT_W'(8);
      3'd6:    return CNT_W'(10);
      3'd7:    return CNT_W'(14);
      default: return CNT_W'(c) + CNT_W'(1);
    endcase
  endfunction

  // 0..3 -> 2,3,4,6 clocks
  function automatic logic [CNT_W-1:0] page_clks(input logic [1:0] c);
    return (c == 2'd3) ? CNT_W'(6) : CNT_W'(c) + CNT_W'(2);
  endfunction

  // 0..3 -> 1,4,8,16 beats
  function automatic logic [CNT_W-1:0] burst_beats(input logic [1:0] c);
    return (c == 2'd0) ? CNT_W'(1) : CNT_W'(2) << c;
  endfunction

  function automatic smem_tm_t decode_tm(input logic [CFG_W-1:0] w);
    smem_tm_t t;
    t.beats = burst_beats(w[1:0]);
    t.pga   = page_clks(w[3:2]);
    t.ahd   = short_clks(w[5:4]);
    t.chd   = short_clks(w[7:6]);
    t.acc   = acc_clks(w[10:8]);
    t.csu   = short_clks(w[12:11]);
    t.asu   = short_clks(w[14:13]);
    t.ok    = (w[16:15] == 2'b00);
    return t;
  endfunction
endpackage

// File: rtl/smem_cfg_reg.sv
module smem_cfg_reg
  import smem_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 17'h00700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             start,
  output logic [CFG_W-1:0] cfg_q,
  output smem_tm_t         tm_live,
  output smem_tm_t         tm_act
);
  logic [CFG_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST_CFG;
      act_q <= RST_CFG;
    end else begin
      if (wr_en) cfg_q <= wr_data;
      if (start) act_q <= cfg_q;
    end
  end

  assign tm_live = decode_tm(cfg_q);
  assign tm_act  = decode_tm(act_q);

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data))) else $error("cfg readback"); // R2
endmodule

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
  import smem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  smem_tm_t tm_live,
  input  smem_tm_t tm_act,
  output logic     ready,
  output logic     start,
  output logic     cs_n,
  output logic     oe_n,
  output logic     adv,
  output logic     capture,
  output logic     done,
  output logic     err
);
  typedef enum logic [2:0] {S_IDLE, S_ASU, S_CSU, S_ACC, S_PAGE, S_CHD, S_AHD} st_e;

  st_e              st_q, st_d, tail_st;
  logic [CNT_W-1:0] cnt_q, cnt_d, left_q, left_d, tail_cnt;
  smem_tm_t         tm;
  logic             idle, last, reject, fin;

  assign idle    = (st_q == S_IDLE);
  assign tm      = idle ? tm_live : tm_act;
  assign last    = (cnt_q == CNT_W'(1));
  assign start   = idle && req_valid && tm.ok;
  assign reject  = idle && req_valid && !tm.ok;
  assign capture = (st_q == S_ACC || st_q == S_PAGE) && last;

  // phase that follows the final beat
  always_comb begin
    if (tm.chd != '0) begin
      tail_st = S_CHD; tail_cnt = tm.chd;
    end else if (tm.ahd != '0) begin
      tail_st = S_AHD; tail_cnt = tm.ahd;
    end else begin
      tail_st = S_IDLE; tail_cnt = '0;
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q - CNT_W'(1);
    left_d = left_q;
    case (st_q)
      S_IDLE: begin
        cnt_d = cnt_q;
        if (start) begin
          left_d = tm.beats - CNT_W'(1);
          if (tm.asu != '0) begin
            st_d = S_ASU; cnt_d = tm.asu;
          end else if (tm.csu != '0) begin
            st_d = S_CSU; cnt_d = tm.csu;
          end else begin
            st_d = S_ACC; cnt_d = tm.acc;
          end
        end
      end
      S_ASU: if (last) begin
        if (tm.csu != '0) begin
          st_d = S_CSU; cnt_d = tm.csu;
        end else begin
          st_d = S_ACC; cnt_d = tm.acc;
        end
      end
      S_CSU: if (last) begin
        st_d = S_ACC; cnt_d = tm.acc;
      end
      S_ACC, S_PAGE: if (last) begin
        if (left_q != '0) begin
          st_d = S_PAGE; cnt_d = tm.pga; left_d = left_q - CNT_W'(1);
        end else begin
          st_d = tail_st; cnt_d = tail_cnt;
        end
      end
      S_CHD: if (last) begin
        if (tm.ahd != '0) begin
          st_d = S_AHD; cnt_d = tm.ahd;
        end else begin
          st_d = S_IDLE; cnt_d = '0;
        end
      end
      S_AHD: if (last) begin
        st_d = S_IDLE; cnt_d = '0;
      end
      default: begin
        st_d = S_IDLE; cnt_d = '0;
      end
    endcase
  end

  assign fin = !idle && (st_d == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      done   <= fin || reject;
      err    <= reject;
    end
  end

  assign ready = idle;
  assign adv   = !idle;
  assign cs_n  = !(st_q inside {S_CSU, S_ACC, S_PAGE, S_CHD});
  assign oe_n  = !(st_q inside {S_ACC, S_PAGE});

  AST_OE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n) else $error("oe outside cs"); // R3
  AST_CS_IN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> adv) else $error("cs outside address"); // R5
  AST_ERR_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && cs_n && !adv)) else $error("err without done"); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready) else $error("done while busy"); // R8
  AST_CAPTURE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !oe_n) else $error("capture without oe"); // R7
endmodule

// File: rtl/smem_beat_dp.sv
module smem_beat_dp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_rdata;
      if (start)        mem_addr <= req_addr;
      else if (capture) mem_addr <= mem_addr + ADDR_W'(1);
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !capture) |=> $stable(mem_addr)) else $error("addr moved"); // R7
endmodule

// File: rtl/smem_rd_seq.sv
module smem_rd_seq
  import smem_pkg::*;
#(
  parameter int               ADDR_W  = 16,
  parameter int               DATA_W  = 16,
  parameter logic [CFG_W-1:0] RST_CFG = 17'h00700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_adv,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_rdata
);
  smem_tm_t tm_live, tm_act;
  logic     start, capture;

  smem_cfg_reg #(.RST_CFG(RST_CFG)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .start(start), .cfg_q(cfg_rdata), .tm_live(tm_live), .tm_act(tm_act)
  );

  smem_phase_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .tm_live(tm_live), .tm_act(tm_act),
    .ready(req_ready), .start(start), .cs_n(mem_cs_n), .oe_n(mem_oe_n),
    .adv(mem_adv), .capture(capture), .done(rsp_done), .err(rsp_err)
  );

  smem_beat_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .capture(capture), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .rd_data(rsp_data), .rd_valid(rsp_valid)
  );

  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)) else $error("data without oe"); // R7
endmodule

// File: tb/test_smem_rd_seq.sv
module test_smem_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [16:0]   cfg_wdata = '0;
  logic [16:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, rsp_done, rsp_err;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic          mem_adv, mem_cs_n, mem_oe_n;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mk_data(input logic [AW-1:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign mem_rdata = mem_oe_n ? '0 : mk_data(mem_addr);

  smem_rd_seq i_smem_rd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .mem_addr(mem_addr),
    .mem_adv(mem_adv), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_rdata(mem_rdata)
  );

  // bench tables, stated from the requirements
  function automatic int b_short(input int c);
    int t[4] = '{0, 1, 2, 4};
    return t[c];
  endfunction
  function automatic int b_acc(input int c);
    int t[8] = '{1, 2, 3, 4, 6, 8, 10, 14};
    return t[c];
  endfunction
  function automatic int b_page(input int c);
    int t[4] = '{2, 3, 4, 6};
    return t[c];
  endfunction
  function automatic int b_beats(input int c);
    int t[4] = '{1, 4, 8, 16};
    return t[c];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [16:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == w, "R2 readback", 32'(cfg_rdata), 32'(w));
  endtask

  // one read with the timing word w; optional write of midw during the cycle
  task automatic run_rd(input logic [16:0] w, input logic [AW-1:0] addr,
                        input bit mid, input logic [16:0] midw, input string tg);
    int a, c, x, bt, pg, p, h, g, b1, b2, b3, b4, b5, tot, beat;
    a  = b_short(int'(w[14:13]));
    c  = b_short(int'(w[12:11]));
    x  = b_acc(int'(w[10:8]));
    bt = b_beats(int'(w[1:0]));
    pg = b_page(int'(w[3:2]));
    h  = b_short(int'(w[7:6]));
    g  = b_short(int'(w[5:4]));
    p  = (bt - 1) * pg;
    b1 = a; b2 = a + c; b3 = b2 + x; b4 = b3 + p; b5 = b4 + h; tot = b5 + g;
    beat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(posedge clk);
    for (int n = 0; n <= tot; n++) begin
      bit e_adv, e_cs, e_oe, e_rdy, e_done, e_val;
      @(negedge clk);
      req_valid = 1'b0;
      e_adv  = (n < tot);
      e_cs   = !(n >= b1 && n < b5);
      e_oe   = !(n >= b2 && n < b4);
      e_rdy  = (n >= tot);
      e_done = (n == tot);
      e_val  = (n >= b3 && n <= b4 && ((n - b3) % pg) == 0);
      chk(mem_adv == e_adv,   {tg, " R5 adv"},  32'(mem_adv),  32'(e_adv));
      chk(mem_cs_n == e_cs,   {tg, " R3 cs_n"}, 32'(mem_cs_n), 32'(e_cs));
      chk(mem_oe_n == e_oe,   {tg, " R4 oe_n"}, 32'(mem_oe_n), 32'(e_oe));
      chk(req_ready == e_rdy, {tg, " R8 ready"}, 32'(req_ready), 32'(e_rdy));
      chk(rsp_done == e_done, {tg, " R8 done"}, 32'(rsp_done), 32'(e_done));
      chk(rsp_valid == e_val, {tg, " R6 valid"}, 32'(rsp_valid), 32'(e_val));
      if (e_val) begin
        chk(rsp_data == mk_data(addr + AW'(beat)), {tg, " R7 data"},
            32'(rsp_data), 32'(mk_data(addr + AW'(beat))));
        beat++;
      end
      if (e_adv)
        chk(mem_addr == addr + AW'(beat), {tg, " R7 addr"},
            32'(mem_addr), 32'(addr + AW'(beat)));
      if (mid && n == 1) begin
        cfg_we = 1'b1; cfg_wdata = midw;
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
  endtask

  task automatic run_err(input logic [16:0] w);
    wr_cfg(w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done && rsp_err, "R9 done+err", {30'd0, rsp_done, rsp_err}, 32'h3);
    chk(mem_cs_n && mem_oe_n && !mem_adv, "R9 strobes idle",
        {29'd0, mem_cs_n, mem_oe_n, mem_adv}, 32'h6);
    @(negedge clk);
    chk(!rsp_done && !rsp_err && req_ready, "R9 single pulse",
        {29'd0, rsp_done, rsp_err, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_oe_n && !mem_adv, "R1 strobes",
        {29'd0, mem_cs_n, mem_oe_n, mem_adv}, 32'h6);
    chk(req_ready && !rsp_valid && !rsp_done && !rsp_err, "R1 status",
        {28'd0, req_ready, rsp_valid, rsp_done, rsp_err}, 32'h8);
    chk(cfg_rdata == 17'h00700, "R1 cfg", 32'(cfg_rdata), 32'h700);

    run_rd(17'h00700, 16'h0100, 0, '0, "R4 default");
    wr_cfg(17'h00000);
    run_rd(17'h00000, 16'h0200, 0, '0, "R3 minimum");
    wr_cfg(17'h07FFF);
    run_rd(17'h07FFF, 16'hFFF8, 0, '0, "R6 maximum");
    wr_cfg(17'h02301);
    run_rd(17'h02301, 16'h0040, 0, '0, "R6 four beats");
    wr_cfg(17'h050F0);
    run_rd(17'h050F0, 16'h0777, 0, '0, "R5 holds");

    // R10: write during a cycle leaves that cycle unchanged
    wr_cfg(17'h06A50);
    run_rd(17'h06A50, 16'h0300, 1, 17'h00002, "R10 old");
    chk(cfg_rdata == 17'h00002, "R10 readback", 32'(cfg_rdata), 32'h2);
    run_rd(17'h00002, 16'h0400, 0, '0, "R10 new");

    run_err(17'h08000);
    run_err(17'h10000);
    run_err(17'h18700);

    for (int i = 0; i < 40; i++) begin
      logic [16:0] w;
      logic [AW-1:0] ad;
      w  = {2'b00, 15'($urandom)};
      ad = AW'($urandom);
      wr_cfg(w);
      run_rd(w, ad, 0, '0, "R3 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule